// File: doc/BRIEF.md
# Serial Converter Output Shifter

This block stands in for the digital output side of a 10-bit sampling converter. A controller drives an active-low chip select and a serial clock. The block takes its sample word from a parallel input at the moment chip select falls. It then sends a 16-bit frame on a data line that can be released to high impedance.

Both control inputs are oversampled by a faster system clock. Synchronizer flip-flops find their edges, and all state changes on the system clock. The data line is shown as a data bit plus an output-enable bit; while the enable is low, the line counts as high impedance. Three further outputs are a track/hold status, a one-cycle strobe when a sample is captured, and a one-cycle flag when the controller lowers chip select too soon after the previous frame ended.

The frame starts with four zeros. The first of these is the extra zero that appears when chip select falls before the first rising clock edge. Ten sample bits follow, most significant first, and then two zeros.

Top module: `adc_frame_shifter`

## Requirements
- R1: While reset is held and after its release with chip select high, sdata_oe=0, hold=0 (0 means track, 1 means hold), sample_strobe=0, quiet_violation=0 and sdata=0.
- R2: A detected chip-select fall captures sample_in, sets hold=1 and sdata_oe=1, and pulses sample_strobe high for exactly one system cycle.
- R3: The frame bit on sdata changes only when a serial-clock fall is detected. After k detected falls since chip select went low, sdata shows frame index k.
- R4: Frame indices 0 to 3 are 0. Index 4+j carries sample bit 9-j for j=0..9. Indices 14 and 15 are 0. A receiver that samples on the 16 rising edges therefore collects the 16-bit word sample<<2, with the first bit received as the MSB.
- R5: hold returns to 0 on the 13th detected rising serial-clock edge after the chip-select fall and stays 1 before that edge.
- R6: sdata_oe returns to 0 on the 16th detected serial-clock fall of a frame.
- R7: A detected chip-select rise sets sdata_oe=0 and hold=0 at once, even mid-frame. Later serial-clock edges change nothing until chip select falls again.
- R8: Serial-clock edges after the 16th in a frame have no effect: sdata_oe stays 0 and sdata stays 0. The next chip-select fall restarts the edge counts from zero.
- R9: A frame ends at its 16th fall or at a chip-select rise while sdata_oe=1, whichever comes first. When a frame ends, a quiet window of QUIET_CYCLES system cycles opens. A chip-select fall detected inside that window pulses quiet_violation for one cycle, and the frame still starts.
- R10: Each change on cs_n or sclk that is held steady takes effect on the third rising system-clock edge that samples the new level (SYNC_STAGES=2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 10 | Parallel sample word, latched when chip select falls |
| cs_n | input | 1 | Active-low chip select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| sdata | output | 1 | Current frame bit, 0 while released |
| sdata_oe | output | 1 | Data line driven when 1, high impedance when 0 |
| hold | output | 1 | 1 in hold mode, 0 in track mode |
| sample_strobe | output | 1 | One-cycle pulse when a sample is captured |
| quiet_violation | output | 1 | One-cycle pulse when chip select falls inside the quiet window |

## Verification
The bench targets these edge cases:
- The 12th and 13th rising edges. A design with an off-by-one count would leave hold mode one edge early or one edge late.
- The 16th fall, plus frames with extra clocks. A design that did not saturate would drive again or wrap the frame around.
- Chip select raised mid-frame. A design that missed this would keep driving the line or stay in hold.
- Two gaps between frames, one inside the quiet window and one well outside it. A design that started its timer at the wrong point would flag the wrong gap.
- Sample words with alternating bits and with isolated end bits. A shifter that was reversed or misaligned would deliver a rotated or mirrored word.

// File: rtl/adc_shift_pkg.sv
package adc_shift_pkg;
  localparam int SMP_W     = 10;
  localparam int LEAD_Z    = 4;
  localparam int TRAIL_Z   = 2;
  localparam int FRAME_LEN = LEAD_Z + SMP_W + TRAIL_Z;
  localparam int TRACK_AT  = 13;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  // Bit shown on the line after idx serial-clock falls.
  function automatic logic frame_bit(input logic [SMP_W-1:0] s,
                                     input logic [CNT_W-1:0] idx);
    int pos;
    logic [SMP_W-1:0] sh;
    pos = int'(idx) - LEAD_Z;
    if (pos < 0 || pos >= SMP_W) return 1'b0;
    sh = s << pos;
    return sh[SMP_W-1];
  endfunction
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RESET_VAL}};
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];

  // R10: an edge pulse lasts one cycle
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] sample_in,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_rise,
  input  logic             sck_fall,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             hold,
  output logic             strobe,
  output logic             frame_end
);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] TRACK_IDX = CNT_W'(TRACK_AT - 1);

  logic [SMP_W-1:0] samp_q;
  logic [CNT_W-1:0] fcnt, rcnt;
  logic             in_frame;

  // named internal events
  logic rise_ok, fall_ok, track_ev, last_fall_ev;
  assign rise_ok      = in_frame && !cs_fall && !cs_rise && sck_rise && (rcnt < FULL);
  assign fall_ok      = in_frame && !cs_fall && !cs_rise && sck_fall && (fcnt < FULL);
  assign track_ev     = rise_ok && (rcnt == TRACK_IDX);
  assign last_fall_ev = fall_ok && (fcnt == LAST_IDX);
  assign frame_end    = last_fall_ev || (cs_rise && sdata_oe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q   <= '0;
      fcnt     <= '0;
      rcnt     <= '0;
      in_frame <= 1'b0;
      sdata_oe <= 1'b0;
      hold     <= 1'b0;
      strobe   <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (cs_fall) begin
        samp_q   <= sample_in;
        fcnt     <= '0;
        rcnt     <= '0;
        in_frame <= 1'b1;
        sdata_oe <= 1'b1;
        hold     <= 1'b1;
        strobe   <= 1'b1;
      end else if (cs_rise) begin
        in_frame <= 1'b0;
        sdata_oe <= 1'b0;
        hold     <= 1'b0;
      end else begin
        if (rise_ok)      rcnt     <= rcnt + 1'b1;
        if (track_ev)     hold     <= 1'b0;
        if (fall_ok)      fcnt     <= fcnt + 1'b1;
        if (last_fall_ev) sdata_oe <= 1'b0;
      end
    end
  end

  assign sdata = sdata_oe & frame_bit(samp_q, fcnt);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (hold && sdata_oe && strobe));
  assert_bit_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall && !cs_rise) |=> $stable(sdata));
  assert_track_at_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && sck_rise && !cs_fall && !cs_rise && rcnt == TRACK_IDX) |=> !hold);
  assert_release_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && sck_fall && !cs_fall && !cs_rise && fcnt == LAST_IDX) |=> !sdata_oe);
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdata_oe && !hold));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt <= FULL) && (rcnt <= FULL));
endmodule

// File: rtl/adc_quiet_timer.sv
module adc_quiet_timer #(
  parameter int QUIET_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic cs_fall,
  output logic violation
);
  localparam int QW = $clog2(QUIET_CYCLES + 1);
  logic [QW-1:0] left;
  logic          window_open;
  assign window_open = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left      <= '0;
      violation <= 1'b0;
    end else begin
      violation <= cs_fall && window_open;
      if (frame_end)        left <= QW'(QUIET_CYCLES);
      else if (window_open) left <= left - 1'b1;
    end
  end

  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(cs_fall));
  assert_window_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> window_open);
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
  import adc_shift_pkg::*;
#(
  parameter int QUIET_CYCLES = 20,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] sample_in,
  input  logic             cs_n,
  input  logic             sclk,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             hold,
  output logic             sample_strobe,
  output logic             quiet_violation
);
  logic cs_rise, cs_fall, sck_rise, sck_fall, frame_end;

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n), .rise(cs_rise), .fall(cs_fall));

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk), .rise(sck_rise), .fall(sck_fall));

  adc_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdata(sdata), .sdata_oe(sdata_oe), .hold(hold), .strobe(sample_strobe),
    .frame_end(frame_end));

  adc_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cs_fall(cs_fall),
    .violation(quiet_violation));

  assert_released_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);
endmodule

// File: tb/adc_frame_shifter_bench.sv
`timescale 1ns/1ps
module adc_frame_shifter_bench;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] sample_in = '0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdata, sdata_oe, hold, sample_strobe, quiet_violation;

  adc_frame_shifter #(.QUIET_CYCLES(Q)) u_adc_frame_shifter (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .cs_n(cs_n), .sclk(sclk),
    .sdata(sdata), .sdata_oe(sdata_oe), .hold(hold), .sample_strobe(sample_strobe),
    .quiet_violation(quiet_violation));

  always #5 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  bit    started = 0;
  string tag = "R1";

  task automatic check(input string t, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int d_cs[4], d_sk[4];
  int m_in, m_oe, m_hold, m_strobe, m_viol, m_f, m_r, m_quiet;
  int m_samp;

  function automatic int model_bit(int s, int idx);
    int j;
    j = idx - 4;
    if (j < 0 || j > 9) return 0;
    return (s >> (9 - j)) & 1;
  endfunction

  always @(posedge clk) begin
    bit csf, csr, skr, skf, fend;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin d_cs[i] = 1; d_sk[i] = 0; end
      m_in = 0; m_oe = 0; m_hold = 0; m_strobe = 0; m_viol = 0;
      m_f = 0; m_r = 0; m_quiet = 0; m_samp = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin d_cs[i] = d_cs[i-1]; d_sk[i] = d_sk[i-1]; end
      d_cs[0] = int'(cs_n); d_sk[0] = int'(sclk);
      csf = (d_cs[3] == 1 && d_cs[2] == 0);
      csr = (d_cs[3] == 0 && d_cs[2] == 1);
      skr = (d_sk[3] == 0 && d_sk[2] == 1);
      skf = (d_sk[3] == 1 && d_sk[2] == 0);
      fend = (csr && m_oe == 1) || (!csf && !csr && m_in == 1 && skf && m_f == 15);
      m_viol = (csf && m_quiet > 0) ? 1 : 0;
      if (fend) m_quiet = Q; else if (m_quiet > 0) m_quiet--;
      m_strobe = 0;
      if (csf) begin
        m_samp = int'(sample_in); m_f = 0; m_r = 0; m_in = 1;
        m_oe = 1; m_hold = 1; m_strobe = 1;
      end else if (csr) begin
        m_in = 0; m_oe = 0; m_hold = 0;
      end else if (m_in == 1) begin
        if (skr && m_r < 16) begin m_r++; if (m_r == 13) m_hold = 0; end
        if (skf && m_f < 16) begin m_f++; if (m_f == 16) m_oe = 0; end
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(tag, "sdata R4", int'(sdata), m_oe ? model_bit(m_samp, m_f) : 0);
      check(tag, "sdata_oe R6", int'(sdata_oe), m_oe);
      check(tag, "hold R5", int'(hold), m_hold);
      check(tag, "sample_strobe R2", int'(sample_strobe), m_strobe);
      check(tag, "quiet_violation R9", int'(quiet_violation), m_viol);
    end
  end

  bit viol_seen;
  always @(negedge clk) if (quiet_violation) viol_seen = 1;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [9:0] s, input int nclk, input int gap,
                       input int exp_viol, input bit chk_latency);
    logic [15:0] rx = '0;
    viol_seen = 0;
    @(negedge clk);
    sample_in = s;
    cs_n = 1'b0;
    if (chk_latency) begin
      wait_n(2);
      check("R10", "oe two edges after cs fall", int'(sdata_oe), 0);
      wait_n(1);
      check("R10", "oe three edges after cs fall", int'(sdata_oe), 1);
      wait_n(3);
    end else wait_n(6);
    for (int k = 1; k <= nclk; k++) begin
      if (k <= 16) rx = {rx[14:0], sdata};
      sclk = 1'b1;
      wait_n(4);
      if (k <= 16) check("R5", $sformatf("hold after rise %0d", k), int'(hold), (k < 13) ? 1 : 0);
      sclk = 1'b0;
      wait_n(4);
    end
    if (nclk >= 16) begin
      check("R4", "received word", int'(rx), int'({4'b0, s, 2'b0}));
      check("R8", "oe after extra clocks", int'(sdata_oe), 0);
    end
    cs_n = 1'b1;
    wait_n(4);
    check("R7", "oe after cs rise", int'(sdata_oe), 0);
    check("R9", "violation seen in frame", int'(viol_seen), exp_viol);
    wait_n(gap);
  endtask

  initial begin
    tag = "R1";
    wait_n(3);
    check("R1", "oe in reset", int'(sdata_oe), 0);
    check("R1", "hold in reset", int'(hold), 0);
    rst_n = 1'b1;
    wait_n(5);
    check("R1", "oe after reset", int'(sdata_oe), 0);
    check("R1", "violation after reset", int'(quiet_violation), 0);
    tag = "R2"; frame(10'h3FF, 16, 60, 0, 1);
    tag = "R3"; frame(10'h2AA, 16, 60, 0, 0);
    tag = "R4"; frame(10'h155, 16, 60, 0, 0);
    tag = "R4"; frame(10'h201, 16, 60, 0, 0);
    tag = "R4"; frame(10'h000, 16, 60, 0, 0);
    tag = "R8"; frame(10'h0F3, 20, 60, 0, 0);
    tag = "R7"; frame(10'h1C7, 8, 5, 0, 0);
    tag = "R9"; frame(10'h3A5, 16, 5, 1, 0);
    tag = "R9"; frame(10'h05A, 16, 60, 1, 0);
    tag = "R8"; frame(10'h2D2, 16, 60, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule